// File: doc/BRIEF.md
# Halfword Byte-Swap DMA Adapter

This adapter sits between a peripheral that moves 16-bit little-endian halfwords and a big-endian memory port that accepts bursts. The peripheral issues a request with a byte offset, a byte length and a direction. The adapter builds the memory address by OR-ing that offset with a high base value, which is held by the surrounding register file. It then runs the transfer as one or more memory bursts. Data moves one 16-bit beat at a time with a valid/ready handshake on each side.

In the normal (swap) mode, the adapter clears bit 0 of the address and of the length. It exchanges the two bytes of every halfword in both directions. Writes are cut into chunks of at most `CHUNK_BYTES` bytes, and each chunk is sent as its own burst at an address that advances by the chunk size. Reads go out as one burst of the aligned length. When the bypass input is high at request time, address, length and data pass through untouched and each request becomes a single burst. A one-cycle completion pulse marks the end of every request.

Top module: `hw_swap_dma`

## Requirements
- R1: The memory address of the first burst equals `req_offset_i | base_i` (bitwise OR, not a sum), with bit 0 cleared in swap mode.
- R2: With `bypass_i` high at acceptance, one burst is issued with the unaligned OR address and the unmodified length. It carries ceil(len/2) beats whose data equals the peripheral data bit for bit, in both directions.
- R3: In swap mode (`bypass_i` low), every burst request has bit 0 of its address and bit 0 of its length at zero.
- R4: In swap-mode writes, each memory beat carries the peripheral halfword with bytes exchanged: `mem_wdata_o[15:8]` = `wdata_i[7:0]` and `mem_wdata_o[7:0]` = `wdata_i[15:8]`, in peripheral beat order.
- R5: A swap-mode read is issued as exactly one burst of the aligned length. Each returned beat reaches `rdata_o` with its two bytes exchanged, in arrival order.
- R6: Swap-mode writes are split into bursts of min(remaining, `CHUNK_BYTES`) bytes. Each next burst address is the previous address plus the previous burst length, and the burst lengths sum to the aligned length.
- R7: A request whose effective length is zero, including an odd length of 1 in swap mode, issues no memory request. `done_o` pulses in the cycle after acceptance.
- R8: `done_o` pulses exactly once per request, in the cycle after the handshake of the last beat of the last burst. `req_ready_o` is high only while no transfer is in flight.
- R9: After reset, `req_ready_o` is 1 and `mem_req_valid_o`, `mem_wdata_valid_o`, `rdata_valid_o` and `done_o` are 0.
- R10: While `mem_req_valid_o` is high and `mem_req_ready_i` is low, the request stays valid with unchanged address and length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| base_i | input | AW | High address base, OR-ed into every address |
| bypass_i | input | 1 | Pass-through mode, sampled at request acceptance |
| req_valid_i | input | 1 | Peripheral request valid |
| req_ready_o | output | 1 | Adapter idle and accepting a request |
| req_write_i | input | 1 | 1 = write to memory, 0 = read from memory |
| req_offset_i | input | AW | Peripheral byte offset |
| req_len_i | input | LW | Transfer length in bytes |
| wdata_valid_i | input | 1 | Peripheral write beat valid |
| wdata_ready_o | output | 1 | Write beat accepted |
| wdata_i | input | 16 | Peripheral write halfword |
| rdata_valid_o | output | 1 | Read beat to peripheral valid |
| rdata_o | output | 16 | Read halfword to peripheral |
| done_o | output | 1 | One-cycle completion pulse |
| mem_req_valid_o | output | 1 | Memory burst request valid |
| mem_req_ready_i | input | 1 | Memory burst request accepted |
| mem_req_write_o | output | 1 | Burst direction |
| mem_req_addr_o | output | AW | Burst start byte address |
| mem_req_len_o | output | LW | Burst length in bytes |
| mem_wdata_valid_o | output | 1 | Memory write beat valid |
| mem_wdata_ready_i | input | 1 | Memory write beat accepted |
| mem_wdata_o | output | 16 | Memory write halfword |
| mem_rdata_valid_i | input | 1 | Memory read beat valid |
| mem_rdata_i | input | 16 | Memory read halfword |

## Verification
The bench sweeps write lengths across several chunk boundaries (63, 64, 65, 128, 129 bytes and the range between) with odd offsets. A design that capped the chunk off by one, failed to advance the address, or lost the tail chunk would show a wrong burst count, address or length. Odd offsets and the one-byte swap request catch an adder used in place of the OR, a missing bit-0 clear, and a zero-length request that wrongly reaches memory. Bypass runs with odd lengths catch alignment or swapping applied where it must not be. Random back-pressure on every handshake exposes a request that drifts while stalled, or a completion pulse that fires early or twice.

// File: rtl/hw_swap_dma_pkg.sv
package hw_swap_dma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WDAT = 2'd2,
    ST_RDAT = 2'd3
  } seq_state_e;
endpackage

// File: rtl/hws_align.sv
module hws_align #(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic [AW-1:0] offset_i,
  input  logic [AW-1:0] base_i,
  input  logic [LW-1:0] len_i,
  input  logic          swap_i,
  output logic [AW-1:0] addr_o,
  output logic [LW-1:0] len_o,
  output logic          zero_o
);
  logic [AW-1:0] raw_addr;

  assign raw_addr = offset_i | base_i;
  assign addr_o   = {raw_addr[AW-1:1], raw_addr[0] & ~swap_i};
  assign len_o    = {len_i[LW-1:1], len_i[0] & ~swap_i};
  assign zero_o   = (len_o == '0);
endmodule

// File: rtl/hws_lane.sv
module hws_lane #(
  parameter int DW = 16
) (
  input  logic          swap_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o
);
  localparam int NB = DW / 8;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    // exchange bytes within each halfword
    localparam int SRC = (b % 2 == 0) ? b + 1 : b - 1;
    assign data_o[8*b +: 8] = swap_i ? data_i[8*SRC +: 8] : data_i[8*b +: 8];
  end
endmodule

// File: rtl/hws_seq.sv
module hws_seq
  import hw_swap_dma_pkg::*;
#(
  parameter int AW          = 32,
  parameter int LW          = 16,
  parameter int CHUNK_BYTES = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic          req_write_i,
  input  logic          bypass_i,
  input  logic [AW-1:0] addr_i,
  input  logic [LW-1:0] len_i,
  input  logic          zero_i,
  output logic          req_ready_o,
  output logic          mem_req_valid_o,
  input  logic          mem_req_ready_i,
  output logic          mem_req_write_o,
  output logic [AW-1:0] mem_req_addr_o,
  output logic [LW-1:0] mem_req_len_o,
  output logic          wr_phase_o,
  output logic          rd_phase_o,
  input  logic          wbeat_i,
  input  logic          rbeat_i,
  output logic          swap_o,
  output logic          done_o
);
  localparam logic [LW-1:0] CHUNK = LW'(CHUNK_BYTES);

  seq_state_e    state_q;
  logic [AW-1:0] addr_q;
  logic [LW-1:0] rem_q, chunk_q, beat_q;
  logic          wr_q, swap_q, done_q;
  logic [LW-1:0] chunk_len, beats;
  logic          last_beat;

  assign chunk_len = (wr_q && swap_q && rem_q > CHUNK) ? CHUNK : rem_q;
  assign beats     = {1'b0, chunk_len[LW-1:1]} + {{(LW-1){1'b0}}, chunk_len[0]};
  assign last_beat = (beat_q == LW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      rem_q   <= '0;
      chunk_q <= '0;
      beat_q  <= '0;
      wr_q    <= 1'b0;
      swap_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          if (zero_i) begin
            done_q <= 1'b1;
          end else begin
            addr_q  <= addr_i;
            rem_q   <= len_i;
            wr_q    <= req_write_i;
            swap_q  <= ~bypass_i;
            state_q <= ST_REQ;
          end
        end
        ST_REQ: if (mem_req_ready_i) begin
          chunk_q <= chunk_len;
          beat_q  <= beats;
          state_q <= wr_q ? ST_WDAT : ST_RDAT;
        end
        ST_WDAT: if (wbeat_i) begin
          beat_q <= beat_q - LW'(1);
          if (last_beat) begin
            addr_q <= addr_q + AW'(chunk_q);
            rem_q  <= rem_q - chunk_q;
            if (rem_q == chunk_q) begin
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              state_q <= ST_REQ;
            end
          end
        end
        ST_RDAT: if (rbeat_i) begin
          beat_q <= beat_q - LW'(1);
          if (last_beat) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o     = (state_q == ST_IDLE);
  assign mem_req_valid_o = (state_q == ST_REQ);
  assign mem_req_write_o = wr_q;
  assign mem_req_addr_o  = addr_q;
  assign mem_req_len_o   = chunk_len;
  assign wr_phase_o      = (state_q == ST_WDAT);
  assign rd_phase_o      = (state_q == ST_RDAT);
  assign swap_o          = swap_q;
  assign done_o          = done_q;
endmodule

// File: rtl/hw_swap_dma.sv
module hw_swap_dma #(
  parameter int AW          = 32,
  parameter int LW          = 16,
  parameter int CHUNK_BYTES = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] base_i,
  input  logic          bypass_i,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_write_i,
  input  logic [AW-1:0] req_offset_i,
  input  logic [LW-1:0] req_len_i,
  input  logic          wdata_valid_i,
  output logic          wdata_ready_o,
  input  logic [15:0]   wdata_i,
  output logic          rdata_valid_o,
  output logic [15:0]   rdata_o,
  output logic          done_o,
  output logic          mem_req_valid_o,
  input  logic          mem_req_ready_i,
  output logic          mem_req_write_o,
  output logic [AW-1:0] mem_req_addr_o,
  output logic [LW-1:0] mem_req_len_o,
  output logic          mem_wdata_valid_o,
  input  logic          mem_wdata_ready_i,
  output logic [15:0]   mem_wdata_o,
  input  logic          mem_rdata_valid_i,
  input  logic [15:0]   mem_rdata_i
);
  logic [AW-1:0] al_addr;
  logic [LW-1:0] al_len;
  logic          al_zero, wr_phase, rd_phase, swap_w;

  hws_align #(.AW(AW), .LW(LW)) align_i (
    .offset_i (req_offset_i),
    .base_i   (base_i),
    .len_i    (req_len_i),
    .swap_i   (~bypass_i),
    .addr_o   (al_addr),
    .len_o    (al_len),
    .zero_o   (al_zero)
  );

  hws_seq #(.AW(AW), .LW(LW), .CHUNK_BYTES(CHUNK_BYTES)) seq_i (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .req_valid_i     (req_valid_i),
    .req_write_i     (req_write_i),
    .bypass_i        (bypass_i),
    .addr_i          (al_addr),
    .len_i           (al_len),
    .zero_i          (al_zero),
    .req_ready_o     (req_ready_o),
    .mem_req_valid_o (mem_req_valid_o),
    .mem_req_ready_i (mem_req_ready_i),
    .mem_req_write_o (mem_req_write_o),
    .mem_req_addr_o  (mem_req_addr_o),
    .mem_req_len_o   (mem_req_len_o),
    .wr_phase_o      (wr_phase),
    .rd_phase_o      (rd_phase),
    .wbeat_i         (mem_wdata_valid_o & mem_wdata_ready_i),
    .rbeat_i         (rdata_valid_o),
    .swap_o          (swap_w),
    .done_o          (done_o)
  );

  assign mem_wdata_valid_o = wr_phase & wdata_valid_i;
  assign wdata_ready_o     = wr_phase & mem_wdata_ready_i;
  assign rdata_valid_o     = rd_phase & mem_rdata_valid_i;

  hws_lane #(.DW(16)) wlane_i (.swap_i(swap_w), .data_i(wdata_i),     .data_o(mem_wdata_o));
  hws_lane #(.DW(16)) rlane_i (.swap_i(swap_w), .data_i(mem_rdata_i), .data_o(rdata_o));
endmodule

// File: rtl/hw_swap_dma_chk.sv
module hw_swap_dma_chk #(
  parameter int AW          = 32,
  parameter int LW          = 16,
  parameter int CHUNK_BYTES = 64
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          swap_i,
  input logic          req_ready_o,
  input logic          mem_req_valid_o,
  input logic          mem_req_ready_i,
  input logic          mem_req_write_o,
  input logic [AW-1:0] mem_req_addr_o,
  input logic [LW-1:0] mem_req_len_o,
  input logic          mem_wdata_valid_o,
  input logic [15:0]   mem_wdata_o,
  input logic [15:0]   wdata_i,
  input logic          rdata_valid_o
);
  AST_SWAP_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && swap_i |-> !mem_req_addr_o[0] && !mem_req_len_o[0]); // R3

  AST_CHUNK_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && mem_req_write_o && swap_i |-> mem_req_len_o <= LW'(CHUNK_BYTES)); // R6

  AST_NO_EMPTY_BURST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> mem_req_len_o != '0); // R7

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i |=>
      mem_req_valid_o && $stable(mem_req_addr_o) && $stable(mem_req_len_o)); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !mem_req_valid_o && !mem_wdata_valid_o && !rdata_valid_o); // R8

  AST_BYPASS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wdata_valid_o && !swap_i |-> mem_wdata_o == wdata_i); // R2
endmodule

bind hw_swap_dma hw_swap_dma_chk #(.AW(AW), .LW(LW), .CHUNK_BYTES(CHUNK_BYTES)) chk_i (
  .clk_i             (clk_i),
  .rst_ni            (rst_ni),
  .swap_i            (swap_w),
  .req_ready_o       (req_ready_o),
  .mem_req_valid_o   (mem_req_valid_o),
  .mem_req_ready_i   (mem_req_ready_i),
  .mem_req_write_o   (mem_req_write_o),
  .mem_req_addr_o    (mem_req_addr_o),
  .mem_req_len_o     (mem_req_len_o),
  .mem_wdata_valid_o (mem_wdata_valid_o),
  .mem_wdata_o       (mem_wdata_o),
  .wdata_i           (wdata_i),
  .rdata_valid_o     (rdata_valid_o)
);

// File: tb/hw_swap_dma_tb_top.sv
module hw_swap_dma_tb_top;
  localparam int AW = 32;
  localparam int LW = 16;
  localparam int CB = 64;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic [AW-1:0] base_i = 32'h00ff_0000;
  logic bypass_i = 1'b0, req_valid_i = 1'b0, req_write_i = 1'b0;
  logic [AW-1:0] req_offset_i = '0;
  logic [LW-1:0] req_len_i = '0;
  logic wdata_valid_i = 1'b0, mem_req_ready_i = 1'b0, mem_wdata_ready_i = 1'b0;
  logic mem_rdata_valid_i = 1'b0;
  logic [15:0] wdata_i = '0, mem_rdata_i = '0;
  logic req_ready_o, wdata_ready_o, rdata_valid_o, done_o;
  logic mem_req_valid_o, mem_req_write_o, mem_wdata_valid_o;
  logic [AW-1:0] mem_req_addr_o;
  logic [LW-1:0] mem_req_len_o;
  logic [15:0] rdata_o, mem_wdata_o;

  hw_swap_dma #(.AW(AW), .LW(LW), .CHUNK_BYTES(CB)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .base_i(base_i), .bypass_i(bypass_i),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_write_i(req_write_i),
    .req_offset_i(req_offset_i), .req_len_i(req_len_i),
    .wdata_valid_i(wdata_valid_i), .wdata_ready_o(wdata_ready_o), .wdata_i(wdata_i),
    .rdata_valid_o(rdata_valid_o), .rdata_o(rdata_o), .done_o(done_o),
    .mem_req_valid_o(mem_req_valid_o), .mem_req_ready_i(mem_req_ready_i),
    .mem_req_write_o(mem_req_write_o), .mem_req_addr_o(mem_req_addr_o),
    .mem_req_len_o(mem_req_len_o), .mem_wdata_valid_o(mem_wdata_valid_o),
    .mem_wdata_ready_i(mem_wdata_ready_i), .mem_wdata_o(mem_wdata_o),
    .mem_rdata_valid_i(mem_rdata_valid_i), .mem_rdata_i(mem_rdata_i)
  );

  int total = 0, bad = 0;
  int cyc = 0, acc_cyc = 0, last_cyc = 0, done_cyc = 0, ndone = 0;
  int nreq = 0, nwb = 0, nrb = 0, wk = 0, rk = 0, pend = 0;
  logic [AW-1:0] rq_addr [0:15];
  logic [LW-1:0] rq_len [0:15];
  logic [15:0] wb [0:255];
  logic [15:0] rb [0:255];
  logic hold_v = 1'b0;
  logic [AW-1:0] hold_a;
  logic [LW-1:0] hold_l;
  logic [15:0] lfsr = 16'hace1;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] wpat(input int k);
    return 16'(k * 16'h0123 + 16'h5a0f);
  endfunction
  function automatic logic [15:0] rpat(input int k);
    return 16'(k * 16'h0871 + 16'h3c4d);
  endfunction
  function automatic logic [15:0] sw(input logic [15:0] d);
    return {d[7:0], d[15:8]};
  endfunction

  // single engine: observe at negedge, drive just after posedge
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (rst_ni) begin
        if (req_valid_i && req_ready_o) acc_cyc = cyc;
        if (mem_req_valid_o) begin
          if (hold_v) chk(mem_req_addr_o == hold_a && mem_req_len_o == hold_l, "R10",
                          longint'(mem_req_addr_o), longint'(hold_a));
          if (mem_req_ready_i) begin
            if (nreq < 16) begin
              rq_addr[nreq] = mem_req_addr_o;
              rq_len[nreq] = mem_req_len_o;
            end
            nreq++;
            if (!mem_req_write_o) pend += (int'(mem_req_len_o) + 1) / 2;
            hold_v = 1'b0;
          end else begin
            hold_v = 1'b1;
            hold_a = mem_req_addr_o;
            hold_l = mem_req_len_o;
          end
        end
        if (mem_wdata_valid_o && mem_wdata_ready_i) begin
          if (nwb < 256) wb[nwb] = mem_wdata_o;
          nwb++; wk++; last_cyc = cyc;
        end
        if (rdata_valid_o) begin
          if (nrb < 256) rb[nrb] = rdata_o;
          nrb++; last_cyc = cyc;
        end
        if (mem_rdata_valid_i) begin
          pend--; rk++;
        end
        if (done_o) begin
          ndone++; done_cyc = cyc;
        end
      end
      @(posedge clk); #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      mem_req_ready_i   = lfsr[0] | lfsr[3];
      mem_wdata_ready_i = lfsr[1] | lfsr[4];
      wdata_valid_i     = lfsr[2] | lfsr[5];
      wdata_i           = wpat(wk);
      mem_rdata_valid_i = (pend > 0) && (lfsr[6] | lfsr[7]);
      mem_rdata_i       = rpat(rk);
    end
  end

  task automatic xfer(input bit wr, input bit byp, input int off, input int len);
    int a, l, n, rem, exp_n, w;
    nreq = 0; nwb = 0; nrb = 0; wk = 0; rk = 0; ndone = 0; pend = 0;
    acc_cyc = 0; done_cyc = 0; last_cyc = 0;
    @(posedge clk); #1;
    req_valid_i = 1'b1; req_write_i = wr; bypass_i = byp;
    req_offset_i = AW'(off); req_len_i = LW'(len);
    do @(negedge clk); while (!req_ready_o);
    @(posedge clk); #1;
    req_valid_i = 1'b0;
    w = 0;
    while (ndone == 0 && w < 5000) begin
      @(negedge clk); w++;
    end
    if (w >= 5000) chk(1'b0, "watchdog", 0, 1);
    repeat (3) @(negedge clk);
    chk(ndone == 1, "R8", ndone, 1);
    a = off | int'(base_i);
    l = len;
    if (!byp) begin
      a = a & ~1; l = l & ~1;
    end
    if (l == 0) begin
      chk(nreq == 0, "R7", nreq, 0);
      chk(done_cyc == acc_cyc + 1, "R7", done_cyc - acc_cyc, 1);
      return;
    end
    exp_n = (wr && !byp) ? (l + CB - 1) / CB : 1;
    chk(nreq == exp_n, byp ? "R2" : (wr ? "R6" : "R5"), nreq, exp_n);
    rem = l;
    for (int i = 0; i < exp_n && i < nreq && i < 16; i++) begin
      int c;
      c = (wr && !byp && rem > CB) ? CB : rem;
      chk(int'(rq_addr[i]) == a, byp ? "R2" : (i == 0 ? "R1" : "R6"), rq_addr[i], a);
      chk(int'(rq_len[i]) == c, byp ? "R2" : "R3", rq_len[i], c);
      a += c; rem -= c;
    end
    n = (l + 1) / 2;
    if (wr) begin
      chk(nwb == n, byp ? "R2" : "R4", nwb, n);
      for (int k = 0; k < n && k < nwb && k < 256; k++)
        chk(wb[k] == (byp ? wpat(k) : sw(wpat(k))), byp ? "R2" : "R4", wb[k],
            byp ? wpat(k) : sw(wpat(k)));
    end else begin
      chk(nrb == n, byp ? "R2" : "R5", nrb, n);
      for (int k = 0; k < n && k < nrb && k < 256; k++)
        chk(rb[k] == (byp ? rpat(k) : sw(rpat(k))), byp ? "R2" : "R5", rb[k],
            byp ? rpat(k) : sw(rpat(k)));
    end
    chk(done_cyc == last_cyc + 1, "R8", done_cyc - last_cyc, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready_o == 1'b1, "R9", req_ready_o, 1);
    chk(!mem_req_valid_o && !mem_wdata_valid_o && !rdata_valid_o, "R9", mem_req_valid_o, 0);
    chk(done_o == 1'b0, "R9", done_o, 0);
    @(posedge clk); #1 rst_ni = 1'b1;
    for (int len = 0; len <= 140; len++) xfer(1'b1, 1'b0, 32'h0003_0101 + len * 6, len);
    for (int len = 0; len <= 70; len++)  xfer(1'b0, 1'b0, 32'h0001_0203 + len * 2, len);
    for (int len = 0; len <= 9; len++)   xfer(1'b1, 1'b1, 32'h0003_0101 + len, len);
    xfer(1'b1, 1'b1, 32'h0000_0011, 131);
    for (int len = 0; len <= 9; len++)   xfer(1'b0, 1'b1, 32'h0002_0105 + len, len);
    base_i = 32'h8000_0000;
    xfer(1'b1, 1'b0, 32'h0000_0fff, 129);
    xfer(1'b0, 1'b0, 32'h0000_0fff, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule